// File: doc/BRIEF.md
# Two-Level Tag Hit/Miss Filter

This block models where an access would be found in a two-level cache hierarchy, tracking tags only. Instruction fetches look up a private first-level instruction tag store and memory accesses look up a private first-level data tag store. Both first-level stores share one unified second-level tag store, which is consulted only when the first level misses. No data is held. The block reports the level that served each request and keeps separate access and miss counts for each store.

A requester presents an address together with a valid flag and holds both until it sees ready. The accepted request is looked up in a single cycle. One cycle later a done pulse appears on that requester's channel, together with a level code. Only one request is accepted per cycle, so the second-level store sees at most one lookup per cycle. When both requesters ask in the same cycle, the memory-access request goes first and the fetch is held off for one cycle.

Every store is set-associative. A miss installs the line into the way that the set's rotating fill pointer names. Sets start empty, so the fill order matches arrival order and the oldest line in a full set is replaced first. Hits do not move the pointer.

Top module: `tag_hier_filter`

## Requirements
- R1: An accepted fetch is looked up only in the instruction first-level store and adds one to the fetch access count. An accepted memory access is looked up only in the data first-level store and adds one to the memory access count.
- R2: A first-level hit returns level code 0 and leaves both second-level counts unchanged.
- R3: A first-level miss adds one to that side's miss count and one to the second-level access count. It returns code 1 if the second level holds the line and code 2 otherwise. A code-2 result also adds one to the second-level miss count.
- R4: A first-level miss installs the line in that first-level store whatever the second level returns, so an immediate repeat of the address returns code 0.
- R5: A second-level miss installs the line in the second level, so a later first-level miss on that line returns code 1.
- R6: The second-level access count always equals the sum of the fetch and memory miss counts, as long as no counter has saturated.
- R7: When both requesters are valid in the same cycle, the memory access is served, fetch_ready is low during that cycle, and the held fetch is served in the next cycle.
- R8: The done pulse and level code appear in the cycle after acceptance, on the requester's own done output only. The code is never 3.
- R9: Every counter saturates at its all-ones value instead of wrapping.
- R10: A miss in a full set replaces the line that was installed earliest in that set. Hits do not change the replacement order.
- R11: After reset all stores are empty, all counters read 0, no done is raised and fetch_ready is high.
- R12: The two first-level stores are independent. A line brought in by a memory access does not hit on a fetch of the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_valid | input | 1 | Instruction fetch request |
| fetch_addr | input | ADDR_W | Fetch byte address |
| fetch_ready | output | 1 | Fetch accepted this cycle when high |
| mem_valid | input | 1 | Load/store request (always accepted) |
| mem_addr | input | ADDR_W | Load/store byte address |
| fetch_done | output | 1 | Result for the fetch accepted last cycle |
| mem_done | output | 1 | Result for the memory access accepted last cycle |
| resp_level | output | 2 | 0 first-level hit, 1 second-level hit, 2 missed both |
| cnt_fetch_acc | output | CNT_W | Instruction first-level accesses |
| cnt_fetch_miss | output | CNT_W | Instruction first-level misses |
| cnt_mem_acc | output | CNT_W | Data first-level accesses |
| cnt_mem_miss | output | CNT_W | Data first-level misses |
| cnt_l2_acc | output | CNT_W | Second-level accesses |
| cnt_l2_miss | output | CNT_W | Second-level misses |

## Verification
The assertions assume that reset is held low before the first clock edge, and that a fetch requester keeps fetch_valid and fetch_addr steady while fetch_ready is low. The bench drives inputs only on falling edges. It holds a colliding fetch until it is accepted, and it drops every request one cycle after acceptance. The checks on the second-level balance and on the miss-count steps are guarded against saturated counters, so a narrow-counter instance can run the same stimulus without tripping them.

// File: rtl/tag_hier_filter.sv
module tag_hier_filter #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 6,
  parameter int L1_SETS  = 32,
  parameter int L1_WAYS  = 8,
  parameter int L2_SETS  = 64,
  parameter int L2_WAYS  = 16,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic              fetch_ready,
  input  logic              mem_valid,
  input  logic [ADDR_W-1:0] mem_addr,
  output logic              fetch_done,
  output logic              mem_done,
  output logic [1:0]        resp_level,
  output logic [CNT_W-1:0]  cnt_fetch_acc,
  output logic [CNT_W-1:0]  cnt_fetch_miss,
  output logic [CNT_W-1:0]  cnt_mem_acc,
  output logic [CNT_W-1:0]  cnt_mem_miss,
  output logic [CNT_W-1:0]  cnt_l2_acc,
  output logic [CNT_W-1:0]  cnt_l2_miss
);
  localparam int L1_IW = $clog2(L1_SETS);
  localparam int L2_IW = $clog2(L2_SETS);
  localparam int L1_TW = ADDR_W - OFF_W - L1_IW;
  localparam int L2_TW = ADDR_W - OFF_W - L2_IW;
  localparam int L1_PW = $clog2(L1_WAYS);
  localparam int L2_PW = $clog2(L2_WAYS);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [L1_TW-1:0]   it_tag [L1_SETS][L1_WAYS];
  logic [L1_TW-1:0]   dt_tag [L1_SETS][L1_WAYS];
  logic [L2_TW-1:0]   u_tag  [L2_SETS][L2_WAYS];
  logic [L1_WAYS-1:0] it_vld [L1_SETS];
  logic [L1_WAYS-1:0] dt_vld [L1_SETS];
  logic [L2_WAYS-1:0] u_vld  [L2_SETS];
  logic [L1_PW-1:0]   it_ptr [L1_SETS];
  logic [L1_PW-1:0]   dt_ptr [L1_SETS];
  logic [L2_PW-1:0]   u_ptr  [L2_SETS];

  logic              sel_d, fire, l1_hit, l2_hit;
  logic [ADDR_W-1:0] a;
  logic [L1_IW-1:0]  i1;
  logic [L1_TW-1:0]  t1;
  logic [L2_IW-1:0]  i2;
  logic [L2_TW-1:0]  t2;
  logic [L1_WAYS-1:0] ih, dh;
  logic [L2_WAYS-1:0] uh;
  logic              unused_off;

  assign sel_d       = mem_valid;
  assign fetch_ready = ~mem_valid;
  assign fire        = mem_valid | fetch_valid;
  assign a           = sel_d ? mem_addr : fetch_addr;
  assign i1          = a[OFF_W +: L1_IW];
  assign t1          = a[ADDR_W-1 -: L1_TW];
  assign i2          = a[OFF_W +: L2_IW];
  assign t2          = a[ADDR_W-1 -: L2_TW];
  assign unused_off  = ^{fetch_addr[OFF_W-1:0], mem_addr[OFF_W-1:0]};

  always_comb begin
    for (int w = 0; w < L1_WAYS; w++) begin
      ih[w] = it_vld[i1][w] && (it_tag[i1][w] == t1);
      dh[w] = dt_vld[i1][w] && (dt_tag[i1][w] == t1);
    end
    for (int w = 0; w < L2_WAYS; w++)
      uh[w] = u_vld[i2][w] && (u_tag[i2][w] == t2);
  end

  assign l1_hit = sel_d ? |dh : |ih;
  assign l2_hit = |uh;

  always_ff @(posedge clk) begin
    if (fire && !l1_hit) begin
      if (sel_d) dt_tag[i1][dt_ptr[i1]] <= t1;
      else       it_tag[i1][it_ptr[i1]] <= t1;
      if (!l2_hit) u_tag[i2][u_ptr[i2]] <= t2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < L1_SETS; s++) begin
        it_vld[s] <= '0;
        dt_vld[s] <= '0;
        it_ptr[s] <= '0;
        dt_ptr[s] <= '0;
      end
      for (int s = 0; s < L2_SETS; s++) begin
        u_vld[s] <= '0;
        u_ptr[s] <= '0;
      end
    end else if (fire && !l1_hit) begin
      if (sel_d) begin
        dt_vld[i1][dt_ptr[i1]] <= 1'b1;
        dt_ptr[i1] <= dt_ptr[i1] + 1'b1;
      end else begin
        it_vld[i1][it_ptr[i1]] <= 1'b1;
        it_ptr[i1] <= it_ptr[i1] + 1'b1;
      end
      if (!l2_hit) begin
        u_vld[i2][u_ptr[i2]] <= 1'b1;
        u_ptr[i2] <= u_ptr[i2] + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetch_done <= 1'b0;
      mem_done   <= 1'b0;
      resp_level <= 2'd0;
    end else begin
      fetch_done <= fire && !sel_d;
      mem_done   <= fire && sel_d;
      if (fire) resp_level <= l1_hit ? 2'd0 : (l2_hit ? 2'd1 : 2'd2);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_fetch_acc  <= '0;
      cnt_fetch_miss <= '0;
      cnt_mem_acc    <= '0;
      cnt_mem_miss   <= '0;
      cnt_l2_acc     <= '0;
      cnt_l2_miss    <= '0;
    end else if (fire) begin
      if (sel_d) begin
        if (cnt_mem_acc != CMAX) cnt_mem_acc <= cnt_mem_acc + 1'b1;
        if (!l1_hit && cnt_mem_miss != CMAX) cnt_mem_miss <= cnt_mem_miss + 1'b1;
      end else begin
        if (cnt_fetch_acc != CMAX) cnt_fetch_acc <= cnt_fetch_acc + 1'b1;
        if (!l1_hit && cnt_fetch_miss != CMAX) cnt_fetch_miss <= cnt_fetch_miss + 1'b1;
      end
      if (!l1_hit && cnt_l2_acc != CMAX) cnt_l2_acc <= cnt_l2_acc + 1'b1;
      if (!l1_hit && !l2_hit && cnt_l2_miss != CMAX) cnt_l2_miss <= cnt_l2_miss + 1'b1;
    end
  end

  logic [CNT_W:0] miss_sum;
  assign miss_sum = {1'b0, cnt_fetch_miss} + {1'b0, cnt_mem_miss};

  // R8
  level_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_done || mem_done) |-> resp_level != 2'd3);

  // R8
  one_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({fetch_done, mem_done}));

  // R6
  l2_balance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_sum < {1'b0, CMAX}) |-> ({1'b0, cnt_l2_acc} == miss_sum));

  // R2
  l1_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((fetch_done || mem_done) && resp_level == 2'd0)
      |-> (cnt_l2_acc == $past(cnt_l2_acc) && cnt_l2_miss == $past(cnt_l2_miss)));

  // R3
  mem_miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_done && resp_level != 2'd0 && $past(cnt_mem_miss) != CMAX)
      |-> cnt_mem_miss == $past(cnt_mem_miss) + 1'b1);

  // R9
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_l2_acc >= $past(cnt_l2_acc) && cnt_mem_acc >= $past(cnt_mem_acc)
      && cnt_fetch_acc >= $past(cnt_fetch_acc));
endmodule

// File: tb/tb_tag_hier_filter.sv
`timescale 1ns/100ps
module tb_tag_hier_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fetch_valid = 1'b0, mem_valid = 1'b0;
  logic [31:0] fetch_addr = '0, mem_addr = '0;
  logic fetch_ready, fetch_done, mem_done;
  logic [1:0] resp_level;
  logic [31:0] c_fa, c_fm, c_ma, c_mm, c_la, c_lm;
  logic s_fr, s_fd, s_md;
  logic [1:0] s_lv;
  logic [2:0] s_fa, s_fm, s_ma, s_mm, s_la, s_lm;

  int n_run = 0, n_fail = 0;
  int e_fa = 0, e_fm = 0, e_ma = 0, e_mm = 0, e_la = 0, e_lm = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  tag_hier_filter dut (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(fetch_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .fetch_done(fetch_done), .mem_done(mem_done), .resp_level(resp_level),
    .cnt_fetch_acc(c_fa), .cnt_fetch_miss(c_fm), .cnt_mem_acc(c_ma),
    .cnt_mem_miss(c_mm), .cnt_l2_acc(c_la), .cnt_l2_miss(c_lm));

  tag_hier_filter #(.CNT_W(3)) dut_sat (
    .clk(clk), .rst_n(rst_n), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
    .fetch_ready(s_fr), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .fetch_done(s_fd), .mem_done(s_md), .resp_level(s_lv),
    .cnt_fetch_acc(s_fa), .cnt_fetch_miss(s_fm), .cnt_mem_acc(s_ma),
    .cnt_mem_miss(s_mm), .cnt_l2_acc(s_la), .cnt_l2_miss(s_lm));

  task automatic chk(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_counts(input string req);
    chk({req, " fetch acc"}, c_fa, e_fa);
    chk({req, " fetch miss"}, c_fm, e_fm);
    chk({req, " mem acc"}, c_ma, e_ma);
    chk({req, " mem miss"}, c_mm, e_mm);
    chk({req, " l2 acc"}, c_la, e_la);
    chk({req, " l2 miss"}, c_lm, e_lm);
  endtask

  function automatic logic [31:0] mk(input int tag, input int idx);
    return (32'(tag) << 12) | (32'(idx) << 6) | 32'h4;
  endfunction

  task automatic tally(input bit is_d, input logic [1:0] code);
    if (is_d) e_ma++; else e_fa++;
    if (code != 0) begin
      if (is_d) e_mm++; else e_fm++;
      e_la++;
    end
    if (code == 2) e_lm++;
  endtask

  task automatic access(input bit is_d, input logic [31:0] a, input logic [1:0] exp, input string req);
    @(negedge clk);
    if (is_d) begin mem_valid = 1; mem_addr = a; end
    else begin fetch_valid = 1; fetch_addr = a; end
    @(posedge clk); #1;
    chk({req, " R8 done on own channel"}, is_d ? mem_done : fetch_done, 1);
    chk({req, " R8 other channel quiet"}, is_d ? fetch_done : mem_done, 0);
    chk({req, " level"}, resp_level, exp);
    @(negedge clk);
    mem_valid = 0; fetch_valid = 0;
    tally(is_d, exp);
    chk_counts({req, " R1 R3"});
  endtask

  task automatic t_reset;
    #1;
    chk("R11 fetch_ready", fetch_ready, 1);
    chk("R11 fetch_done", fetch_done, 0);
    chk("R11 mem_done", mem_done, 0);
    chk_counts("R11");
  endtask

  task automatic t_split;
    logic [31:0] x = mk(3, 1);
    access(0, x, 2'd2, "R3 cold fetch");
    access(0, x, 2'd0, "R4 R2 fetch repeat");
    access(1, x, 2'd1, "R12 R5 data same addr");
    access(1, x, 2'd0, "R4 R2 data repeat");
    chk("R6 balance", c_la, c_fm + c_mm);
  endtask

  task automatic t_fifo;
    for (int k = 0; k < 9; k++) access(1, mk(16 + k, 0), 2'd2, "R10 fill");
    access(1, mk(16, 0), 2'd1, "R10 R5 oldest evicted");
    access(1, mk(18, 0), 2'd0, "R10 third kept");
    access(1, mk(17, 0), 2'd1, "R10 second evicted");
    access(1, mk(24, 0), 2'd0, "R10 newest kept");
    chk("R6 balance", c_la, c_fm + c_mm);
  endtask

  task automatic t_collide;
    logic [31:0] y = mk(5, 2);
    @(negedge clk);
    mem_valid = 1; mem_addr = y; fetch_valid = 1; fetch_addr = y;
    #1 chk("R7 fetch_ready low", fetch_ready, 0);
    @(posedge clk); #1;
    chk("R7 mem served", mem_done, 1);
    chk("R7 fetch held", fetch_done, 0);
    chk("R7 mem level", resp_level, 2);
    @(negedge clk);
    mem_valid = 0;
    tally(1, 2'd2);
    #1 chk("R7 fetch_ready back", fetch_ready, 1);
    @(posedge clk); #1;
    chk("R7 fetch served next", fetch_done, 1);
    chk("R7 fetch level", resp_level, 1);
    @(negedge clk);
    fetch_valid = 0;
    tally(0, 2'd1);
    chk_counts("R7");
    @(posedge clk); #1;
    chk("R8 done drops", fetch_done | mem_done, 0);
  endtask

  function automatic int sat7(input int v);
    return v > 7 ? 7 : v;
  endfunction

  task automatic t_sat;
    for (int k = 0; k < 3; k++) access(1, mk(40 + k, 7), 2'd2, "R9 extra");
    chk("R9 mem acc sat", s_ma, sat7(e_ma));
    chk("R9 mem miss sat", s_mm, sat7(e_mm));
    chk("R9 fetch acc sat", s_fa, sat7(e_fa));
    chk("R9 fetch miss sat", s_fm, sat7(e_fm));
    chk("R9 l2 acc sat", s_la, sat7(e_la));
    chk("R9 l2 miss sat", s_lm, sat7(e_lm));
    chk("R9 saturated at max", s_lm, 7);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    t_split();
    t_fifo();
    t_collide();
    t_sat();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule